// File: doc/BRIEF.md
# Dual-Half Hamming Parity Generator

This block builds a single-error-correcting Hamming code over a 512-byte chunk while its bytes stream past. The chunk is handled as two independent 256-byte halves. For each half the block keeps sixteen line-parity bits, formed from the byte indices, and six column-parity bits, formed from the bit positions inside each byte. The result is six parity bytes in total. The block only generates the code. Locating and fixing a flipped bit from a syndrome is left to the consumer.

Software-style control arrives as 8-bit mode codes:

- 0xF4 clears the engine. One dummy read must follow it before the engine can be armed.
- 0xB4 starts accumulation over the bytes that follow.
- 0xD4 turns the read port into a result port. That port hands out the six parity bytes as three 16-bit words in an interleaved order.

All parity bits leave the block inverted. An erased half of all 0xFF bytes therefore yields an all-ones code.

Top module: `ecc_dual_hamming`

## Requirements
- R1: After synchronous reset the engine is idle and `rd_word` reads 0. In this state a 0xB4 code does not start accumulation.
- R2: Mode code 0xF4 clears both halves' parity state and the byte counter, and the engine then waits for one dummy read (`rd_en` pulse). A 0xB4 code given before that dummy read is ignored.
- R3: After the dummy read, 0xB4 starts accumulation. A byte is taken only when `byte_valid` is high, accumulation is active, no mode code is written in the same cycle, and fewer than 512 bytes have been taken since the last 0xF4. Bytes outside these conditions have no effect on the result.
- R4: Bytes 0 to 255 of the chunk feed the first half's parity and bytes 256 to 511 feed the second half's. The switch happens automatically at the 256th byte.
- R5: For index bit k (k = 0..7) of a byte's position within its half, the byte's XOR parity is folded into line bit 2k+1 when the index bit is 1, and into line bit 2k when it is 0. The line bits are presented inverted.
- R6: Column bits use the same pairing over bit positions j (0..7) of each byte, giving CP5..CP0. The column byte is {~CP5..~CP0, 1, 1}, with the inverted column bits in bits 7:2 and bits 1:0 fixed at 1.
- R7: After mode code 0xD4, successive reads return three words. Word 0 is {first-half LP7..0, first-half LP15..8}. Word 1 is {second-half LP7..0, first-half column byte}. Word 2 is {second-half column byte, second-half LP15..8}. The high byte is given first in each word, and each `rd_en` pulse advances to the next word.
- R8: Reads after the third word keep returning word 2. The parity values are held until the next 0xF4. A new 0xD4 restarts at word 0.
- R9: Any mode code other than 0xF4, 0xB4 and 0xD4 leaves the engine's state unchanged.
- R10: Outside result mode, `rd_word` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode code write strobe |
| mode_code | input | 8 | Mode code (0xF4 clear, 0xB4 start, 0xD4 result) |
| byte_valid | input | 1 | Data byte strobe |
| byte_in | input | 8 | Streamed data byte |
| rd_en | input | 1 | Read strobe (dummy read or result word advance) |
| rd_word | output | 16 | Result word |

## Verification
The bench builds the block with its default of 256 bytes per half. A full 512-byte chunk costs only a few hundred cycles at that size, so the half boundary at byte 255/256 and the 512-byte overrun are exercised directly. Hand-computed single-bit patterns at the first byte of the first half and at the last byte of the second half pin the line and column bit pairing and the word interleave. A behavioural model, fed with erased, random and corrupted chunks, covers skipped dummy reads, stray mode codes and bytes that arrive outside accumulation.

// File: rtl/ecc_hm_pkg.sv
package ecc_hm_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 16;
    localparam int NUM_HALVES = 2;
    localparam int RES_WORDS  = 3;
    localparam int PTR_W      = 2;
    localparam int COLIDX_W   = $clog2(BYTE_W);
    localparam int CP_W       = 2 * COLIDX_W;

    localparam logic [BYTE_W-1:0] MC_CLEAR  = 8'hF4;
    localparam logic [BYTE_W-1:0] MC_CALC   = 8'hB4;
    localparam logic [BYTE_W-1:0] MC_RESULT = 8'hD4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_DUMMY,
        ST_ARMED,
        ST_CALC,
        ST_RESULT
    } eng_state_t;

    // Column parity pairs: odd bit collects positions with index bit k set,
    // even bit collects positions with it clear.
    function automatic logic [CP_W-1:0] col_to_cp(input logic [BYTE_W-1:0] col);
        logic [CP_W-1:0] cp;
        cp = '0;
        for (int k = 0; k < COLIDX_W; k++) begin
            for (int j = 0; j < BYTE_W; j++) begin
                if (((j >> k) & 1) == 1)
                    cp[2*k+1] = cp[2*k+1] ^ col[j];
                else
                    cp[2*k] = cp[2*k] ^ col[j];
            end
        end
        return cp;
    endfunction

    function automatic logic [BYTE_W-1:0] cp_byte(input logic [CP_W-1:0] cp);
        return {~cp, {(BYTE_W-CP_W){1'b1}}};
    endfunction

endpackage

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
    import ecc_hm_pkg::*;
#(
    parameter int HALF_BYTES = 256,
    localparam int CHUNK     = 2 * HALF_BYTES,
    localparam int IDX_W     = $clog2(HALF_BYTES),
    localparam int CNT_W     = $clog2(CHUNK) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [BYTE_W-1:0] mode_code,
    input  logic              byte_valid,
    input  logic              rd_en,
    output logic              clr,
    output logic              accept,
    output logic              half_sel,
    output logic [IDX_W-1:0]  byte_idx,
    output eng_state_t        state,
    output logic [PTR_W-1:0]  rd_ptr
);

    logic [CNT_W-1:0] cnt;
    logic             code_known;

    assign code_known = (mode_code == MC_CLEAR) || (mode_code == MC_CALC) ||
                        (mode_code == MC_RESULT);
    assign clr      = mode_wr && (mode_code == MC_CLEAR);
    assign accept   = !mode_wr && byte_valid && (state == ST_CALC) &&
                      (cnt < CNT_W'(CHUNK));
    assign half_sel = cnt[IDX_W];
    assign byte_idx = cnt[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            rd_ptr <= '0;
        end else if (mode_wr) begin
            case (mode_code)
                MC_CLEAR: begin
                    state <= ST_WAIT_DUMMY;
                    cnt   <= '0;
                end
                MC_CALC: begin
                    if (state == ST_ARMED)
                        state <= ST_CALC;
                end
                MC_RESULT: begin
                    state  <= ST_RESULT;
                    rd_ptr <= '0;
                end
                default: ;
            endcase
        end else begin
            if (state == ST_WAIT_DUMMY && rd_en)
                state <= ST_ARMED;
            if (accept)
                cnt <= cnt + 1'b1;
            if (state == ST_RESULT && rd_en && rd_ptr != PTR_W'(RES_WORDS-1))
                rd_ptr <= rd_ptr + 1'b1;
        end
    end

    a_r3_cnt_limit: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(CHUNK));

    a_r2_wait_dummy: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_DUMMY && !rd_en && !mode_wr) |=> state == ST_WAIT_DUMMY);

    a_r9_unknown_code: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !code_known) |=> $stable(state));

    a_r7_result_entry: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && mode_code == MC_RESULT) |=> (state == ST_RESULT && rd_ptr == '0));

    a_r8_ptr_range: assert property (@(posedge clk) disable iff (rst)
        rd_ptr <= PTR_W'(RES_WORDS-1));

endmodule

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
    import ecc_hm_pkg::*;
#(
    parameter int HALF_BYTES = 256,
    localparam int IDX_W     = $clog2(HALF_BYTES),
    localparam int LP_W      = 2 * IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] din,
    output logic [LP_W-1:0]   lp,
    output logic [BYTE_W-1:0] col
);

    logic byte_par;
    assign byte_par = ^din;

    generate
        for (genvar k = 0; k < IDX_W; k++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    lp[2*k+1] <= 1'b0;
                    lp[2*k]   <= 1'b0;
                end else if (en) begin
                    lp[2*k+1] <= lp[2*k+1] ^ (byte_par & idx[k]);
                    lp[2*k]   <= lp[2*k]   ^ (byte_par & ~idx[k]);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr)
            col <= '0;
        else if (en)
            col <= col ^ din;
    end

    a_r2_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> (lp == '0 && col == '0));

endmodule

// File: rtl/ecc_result_mux.sv
module ecc_result_mux
    import ecc_hm_pkg::*;
#(
    parameter int LP_W = 16
) (
    input  eng_state_t        state,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [LP_W-1:0]   lp_a,
    input  logic [BYTE_W-1:0] col_a,
    input  logic [LP_W-1:0]   lp_b,
    input  logic [BYTE_W-1:0] col_b,
    output logic [WORD_W-1:0] rd_word
);

    logic [LP_W-1:0]   lpn_a, lpn_b;
    logic [BYTE_W-1:0] cpb_a, cpb_b;

    assign lpn_a = ~lp_a;
    assign lpn_b = ~lp_b;
    assign cpb_a = cp_byte(col_to_cp(col_a));
    assign cpb_b = cp_byte(col_to_cp(col_b));

    always_comb begin
        rd_word = '0;
        if (state == ST_RESULT) begin
            case (rd_ptr)
                2'd0:    rd_word = {lpn_a[7:0], lpn_a[15:8]};
                2'd1:    rd_word = {lpn_b[7:0], cpb_a};
                default: rd_word = {cpb_b, lpn_b[15:8]};
            endcase
        end
    end

endmodule

// File: rtl/ecc_dual_hamming.sv
module ecc_dual_hamming
    import ecc_hm_pkg::*;
#(
    parameter int HALF_BYTES = 256,
    localparam int IDX_W     = $clog2(HALF_BYTES),
    localparam int LP_W      = 2 * IDX_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_wr,
    input  logic [7:0]  mode_code,
    input  logic        byte_valid,
    input  logic [7:0]  byte_in,
    input  logic        rd_en,
    output logic [15:0] rd_word
);

    generate
        if (LP_W != WORD_W) begin : g_bad_size
            $error("result word layout needs 256-byte halves");
        end
    endgenerate

    logic             clr, accept, half_sel;
    logic [IDX_W-1:0] byte_idx;
    eng_state_t       state;
    logic [PTR_W-1:0] rd_ptr;

    logic [LP_W-1:0]   lp_h  [NUM_HALVES];
    logic [BYTE_W-1:0] col_h [NUM_HALVES];

    ecc_mode_ctrl #(.HALF_BYTES(HALF_BYTES)) u_ctrl (
        .clk, .rst, .mode_wr, .mode_code, .byte_valid, .rd_en,
        .clr, .accept, .half_sel, .byte_idx, .state, .rd_ptr
    );

    generate
        for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
            ecc_half_acc #(.HALF_BYTES(HALF_BYTES)) u_acc (
                .clk, .rst, .clr,
                .en  (accept && (half_sel == h[0])),
                .idx (byte_idx),
                .din (byte_in),
                .lp  (lp_h[h]),
                .col (col_h[h])
            );
        end
    endgenerate

    ecc_result_mux #(.LP_W(LP_W)) u_mux (
        .state, .rd_ptr,
        .lp_a (lp_h[0]), .col_a (col_h[0]),
        .lp_b (lp_h[1]), .col_b (col_h[1]),
        .rd_word
    );

    a_r4_first_frozen: assert property (@(posedge clk) disable iff (rst)
        (accept && half_sel) |=> ($stable(lp_h[0]) && $stable(col_h[0])));

    a_r4_second_frozen: assert property (@(posedge clk) disable iff (rst)
        (accept && !half_sel) |=> ($stable(lp_h[1]) && $stable(col_h[1])));

    a_r8_hold_in_result: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RESULT && !mode_wr) |=> ($stable(lp_h[0]) && $stable(lp_h[1])));

endmodule

// File: tb/ecc_dual_hamming_bench.sv
module ecc_dual_hamming_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_code = 8'h00;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        rd_en = 1'b0;
    logic [15:0] rd_word;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    ecc_dual_hamming u_ecc_dual_hamming (
        .clk, .rst, .mode_wr, .mode_code, .byte_valid, .byte_in, .rd_en, .rd_word
    );

    // ---------------- behavioural reference model ----------------
    // states: 0 idle, 1 waiting dummy read, 2 armed, 3 accumulating, 4 result
    int m_state = 0;
    int m_ptr = 0;
    byte unsigned q_a[$];
    byte unsigned q_b[$];

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_ptr = 0; q_a.delete(); q_b.delete();
        end else if (mode_wr) begin
            if (mode_code == 8'hF4) begin
                m_state = 1; q_a.delete(); q_b.delete();
            end else if (mode_code == 8'hB4) begin
                if (m_state == 2) m_state = 3;
            end else if (mode_code == 8'hD4) begin
                m_state = 4; m_ptr = 0;
            end
        end else begin
            if (m_state == 1 && rd_en) m_state = 2;
            else if (m_state == 3 && byte_valid && (q_a.size() + q_b.size()) < 512) begin
                if (q_a.size() < 256) q_a.push_back(byte_in);
                else q_b.push_back(byte_in);
            end else if (m_state == 4 && rd_en && m_ptr < 2) m_ptr++;
        end
    end

    function automatic logic [15:0] lines_of(ref byte unsigned q[$]);
        logic [15:0] v = '0;
        foreach (q[i]) begin
            bit p = ^q[i];
            for (int k = 0; k < 8; k++)
                if ((i >> k) & 1) v[2*k+1] ^= p; else v[2*k] ^= p;
        end
        return ~v;
    endfunction

    function automatic logic [7:0] cols_of(ref byte unsigned q[$]);
        logic [7:0] c = '0;
        logic [5:0] cp = '0;
        foreach (q[i]) c ^= q[i];
        for (int k = 0; k < 3; k++)
            for (int j = 0; j < 8; j++)
                if ((j >> k) & 1) cp[2*k+1] ^= c[j]; else cp[2*k] ^= c[j];
        return {~cp, 2'b11};
    endfunction

    function automatic logic [15:0] model_word();
        logic [15:0] la, lb;
        logic [7:0]  ca, cb;
        if (m_state != 4) return 16'h0000;
        la = lines_of(q_a); lb = lines_of(q_b);
        ca = cols_of(q_a);  cb = cols_of(q_b);
        case (m_ptr)
            0:       return {la[7:0], la[15:8]};
            1:       return {lb[7:0], ca};
            default: return {cb, lb[15:8]};
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            logic [15:0] e;
            e = model_word();
            n_cmp++;
            if (rd_word !== e) begin
                n_bad++;
                $display("FAIL %s per-cycle: rd_word=%h expected=%h", cur_req, rd_word, e);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_word=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic put_mode(input logic [7:0] c);
        mode_wr = 1'b1; mode_code = c;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        byte_valid = 1'b1; byte_in = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic start_chunk();
        put_mode(8'hF4);
        pulse_rd();
        put_mode(8'hB4);
    endtask

    task automatic read3(input string req, input logic [15:0] w0,
                         input logic [15:0] w1, input logic [15:0] w2);
        check(req, rd_word, w0); pulse_rd();
        check(req, rd_word, w1); pulse_rd();
        check(req, rd_word, w2); pulse_rd();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state reads 0; 0xB4 from idle does not start
        cur_req = "R1";
        check("R1", rd_word, 16'h0000);
        put_mode(8'hB4);
        put_byte(8'hFE);
        put_mode(8'hD4);
        check("R1", rd_word, 16'hFFFF);

        // R2: 0xB4 before dummy read ignored
        cur_req = "R2";
        put_mode(8'hF4);
        check("R10", rd_word, 16'h0000);
        put_mode(8'hB4);
        put_byte(8'hFE);
        pulse_rd();
        put_byte(8'hFE);
        put_mode(8'hD4);
        read3("R2", 16'hFFFF, 16'hFFFF, 16'hFFFF);

        // R5 R6 R7: first byte of half A with bit0 cleared
        cur_req = "R5";
        start_chunk();
        put_byte(8'hFE);
        for (int i = 1; i < 512; i++) put_byte(8'hFF);
        put_mode(8'hD4);
        read3("R5/R6/R7", 16'hAAAA, 16'hFFAB, 16'hFFFF);

        // R8: further reads return word 2; new 0xD4 restarts
        cur_req = "R8";
        check("R8", rd_word, 16'hFFFF);
        pulse_rd();
        put_mode(8'hD4);
        check("R8", rd_word, 16'hAAAA);
        // R9: stray code in result mode has no effect
        cur_req = "R9";
        put_mode(8'h94);
        check("R9", rd_word, 16'hAAAA);

        // R4: last byte of half B with bit7 cleared; bytes before 0xB4 ignored (R3)
        cur_req = "R4";
        put_mode(8'hF4);
        pulse_rd();
        put_byte(8'h01);
        put_mode(8'hB4);
        for (int i = 0; i < 511; i++) put_byte(8'hFF);
        put_byte(8'h7F);
        // R3: bytes past 512 ignored
        put_byte(8'h01); put_byte(8'h01); put_byte(8'h03);
        put_mode(8'hD4);
        read3("R4/R3", 16'hFFFF, 16'h55FF, 16'h5755);

        // R3: bytes that coincide with a mode write are ignored
        cur_req = "R3";
        start_chunk();
        mode_wr = 1'b1; mode_code = 8'h94; byte_valid = 1'b1; byte_in = 8'hFE;
        @(negedge clk);
        mode_wr = 1'b0; byte_valid = 1'b0;
        put_mode(8'hD4);
        read3("R3", 16'hFFFF, 16'hFFFF, 16'hFFFF);

        // R9 R4: random chunk with stray code mid-stream; model-compared
        cur_req = "R9";
        start_chunk();
        lfsr = 8'hA5;
        for (int i = 0; i < 512; i++) begin
            if (i == 200) put_mode(8'h94);
            put_byte(lfsr);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        put_mode(8'hD4);
        for (int r = 0; r < 4; r++) pulse_rd();

        // R2: clear after results returns to zero output and zero state
        cur_req = "R2";
        put_mode(8'hF4);
        check("R2", rd_word, 16'h0000);
        pulse_rd();
        put_mode(8'hD4);
        read3("R2", 16'hFFFF, 16'hFFFF, 16'hFFFF);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule